// File: doc/BRIEF.md
# Key Group Candidate Enumerator

This block produces candidate 128-bit cipher keys, one per clock, for a pipelined exhaustive key search. The key space is split into groups of sixteen. A group is named by a base key whose two chosen bytes have their two lowest bits cleared. Inside a group, a 2-bit offset `a` fills the low bits of the first chosen byte and a 2-bit offset `b` fills the low bits of the second. This gives sixteen members, and together the groups cover every key exactly once.

A 124-bit group counter supplies every key bit except the four offset bits. A 4-bit member index walks through the sixteen offset combinations. The counter advances each time the member index wraps. A start pulse loads a starting group. The run ends once member 15 of a chosen final group has been issued, and a one-cycle done pulse marks the end. A stall input freezes the output stream so a downstream cipher pipeline can apply backpressure.

Top module: `keyGroupEnum`

## Requirements
- R1: After reset, `keyValid` and `done` are both low.
- R2: Byte i of `keyOut` is bits [8i+7:8i]. Bits [1:0] of byte POS_A (default 0) equal `memberIdx[1:0]`. Bits [1:0] of byte POS_B (default 5) equal `memberIdx[3:2]`. The remaining 124 key bits, taken in ascending bit order, equal `groupIdx` bits 0 to 123 in ascending order.
- R3: On each clock with `keyValid` high, `stall` low and `start` low, where the current key is not the final one, `memberIdx` increases by one.
- R4: When `memberIdx` steps from 15 to 0, `groupIdx` increases by one, modulo 2^124. Otherwise `groupIdx` is unchanged.
- R5: While `keyValid` is high and `stall` is high without `start`, `keyOut`, `groupIdx`, `memberIdx` and `keyValid` hold their values into the next cycle.
- R6: A `start` pulse makes the next cycle show `keyValid` high, `memberIdx` 0 and `groupIdx` equal to `startGroup`. This applies even during a running sweep.
- R7: If member 15 of `finalGroup` is shown with `stall` and `start` low, the next cycle has `keyValid` low and `done` high. `done` is high for exactly one cycle.
- R8: When `startGroup` equals `finalGroup`, exactly 16 keys are issued. When `finalGroup` lies below `startGroup`, the sweep wraps through group 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load `startGroup` and begin a sweep |
| stall | input | 1 | Hold the current candidate |
| startGroup | input | 124 | First group of a sweep |
| finalGroup | input | 124 | Last group of a sweep |
| keyOut | output | 128 | Candidate key |
| groupIdx | output | 124 | Group index of the candidate |
| memberIdx | output | 4 | In-group index: [1:0] is a, [3:2] is b |
| keyValid | output | 1 | Candidate is valid |
| done | output | 1 | One-cycle pulse after the last key |

## Verification
A wrong member or group register shows up on the very next unstalled cycle. It appears as a misplaced offset in the low bits of byte 0 or byte 5, or as a wrong base-key bit, because the key is wired directly from those registers. A bad stop comparison shows within one cycle of member 15 of the final group: either `done` appears too early, or `keyValid` stays high after the point where the sweep must stop. The bench mixes random stall patterns with counter wrap, single-group sweeps and restarts. This exposes both kinds of error against an independent cycle model.

// File: rtl/keyEnumPkg.sv
package keyEnumPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // take startGroup, clear member index
    logic advance;  // step to next candidate
    logic finish;   // current candidate is the last one
  } enumCtl_t;
endpackage

// File: rtl/keyEnumData.sv
module keyEnumData
  import keyEnumPkg::*;
#(
  parameter int KEY_BYTES = 16,
  parameter int POS_A     = 0,
  parameter int POS_B     = 5,
  parameter int OFS_W     = 2,
  localparam int KEY_W    = 8 * KEY_BYTES,
  localparam int IDX_W    = 2 * OFS_W,
  localparam int GRP_W    = KEY_W - IDX_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  enumCtl_t         ctl,
  input  logic [GRP_W-1:0] startGroup,
  input  logic [GRP_W-1:0] finalGroup,
  output logic [GRP_W-1:0] groupQ,
  output logic [IDX_W-1:0] memberQ,
  output logic [KEY_W-1:0] keyComb,
  output logic             isLast
);

  localparam int A_LO = 8 * POS_A;
  localparam int B_LO = 8 * POS_B;

  function automatic bit inA(int k);
    return (k >= A_LO) && (k < A_LO + OFS_W);
  endfunction

  function automatic bit inB(int k);
    return (k >= B_LO) && (k < B_LO + OFS_W);
  endfunction

  // number of offset bits lying below key bit k
  function automatic int holesBelow(int k);
    int n = 0;
    for (int j = 0; j < k; j++)
      if (inA(j) || inB(j)) n++;
    return n;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      groupQ  <= '0;
      memberQ <= '0;
    end else if (ctl.load) begin
      groupQ  <= startGroup;
      memberQ <= '0;
    end else if (ctl.advance && !ctl.finish) begin
      memberQ <= memberQ + 1'b1;
      if (memberQ == '1) groupQ <= groupQ + 1'b1;
    end
  end

  // key wiring: offsets into low bits of the two chosen bytes, group bits elsewhere
  for (genvar k = 0; k < KEY_W; k++) begin : g_keyBit
    if (inA(k)) begin : g_ofsA
      assign keyComb[k] = memberQ[k - A_LO];
    end else if (inB(k)) begin : g_ofsB
      assign keyComb[k] = memberQ[OFS_W + k - B_LO];
    end else begin : g_base
      localparam int GI = k - holesBelow(k);
      assign keyComb[k] = groupQ[GI];
    end
  end

  assign isLast = (memberQ == '1) && (groupQ == finalGroup);

  // R4: group changes only on a member wrap, by exactly one
  p_group_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !ctl.finish && !ctl.load && memberQ != '1) |=> $stable(groupQ));

endmodule

// File: rtl/keyEnumCtrl.sv
module keyEnumCtrl
  import keyEnumPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     stall,
  input  logic     isLast,
  output enumCtl_t ctl,
  output logic     running,
  output logic     doneQ
);

  always_comb begin
    ctl.load    = start;
    ctl.advance = running && !stall && !start;
    ctl.finish  = ctl.advance && isLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      if (ctl.load)        running <= 1'b1;
      else if (ctl.finish) running <= 1'b0;
      doneQ <= ctl.finish;
    end
  end

  // R7: done is a single-cycle pulse with the stream stopped
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !running);

endmodule

// File: rtl/keyGroupEnum.sv
module keyGroupEnum
  import keyEnumPkg::*;
#(
  parameter int KEY_BYTES = 16,
  parameter int POS_A     = 0,
  parameter int POS_B     = 5,
  parameter int OFS_W     = 2,
  localparam int KEY_W    = 8 * KEY_BYTES,
  localparam int IDX_W    = 2 * OFS_W,
  localparam int GRP_W    = KEY_W - IDX_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             stall,
  input  logic [GRP_W-1:0] startGroup,
  input  logic [GRP_W-1:0] finalGroup,
  output logic [KEY_W-1:0] keyOut,
  output logic [GRP_W-1:0] groupIdx,
  output logic [IDX_W-1:0] memberIdx,
  output logic             keyValid,
  output logic             done
);

  enumCtl_t ctl;
  logic     isLast;

  keyEnumCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stall(stall),
    .isLast(isLast), .ctl(ctl), .running(keyValid), .doneQ(done)
  );

  keyEnumData #(
    .KEY_BYTES(KEY_BYTES), .POS_A(POS_A), .POS_B(POS_B), .OFS_W(OFS_W)
  ) i_data (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .startGroup(startGroup), .finalGroup(finalGroup),
    .groupQ(groupIdx), .memberQ(memberIdx), .keyComb(keyOut), .isLast(isLast)
  );

  // R5: stall freezes the stream
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (keyValid && stall && !start) |=>
      (keyValid && $stable(keyOut) && $stable(groupIdx) && $stable(memberIdx)));

  // R3: member index steps by one inside a group
  p_member_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (keyValid && !stall && !start && memberIdx != '1) |=>
      (keyValid && memberIdx == $past(memberIdx) + 1'b1));

  // R4: wrap of member index advances the group
  p_group_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (keyValid && !stall && !start && memberIdx == '1 && groupIdx != finalGroup) |=>
      (keyValid && memberIdx == '0 && groupIdx == $past(groupIdx) + 1'b1));

  // R6: start loads the starting group
  p_start_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (keyValid && memberIdx == '0 && groupIdx == $past(startGroup)));

  // R7: the final key ends the sweep
  p_final_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (keyValid && !stall && !start && memberIdx == '1 && groupIdx == finalGroup) |=>
      (!keyValid && done));

endmodule

// File: tb/test_keyGroupEnum.sv
module test_keyGroupEnum;
  localparam int KEY_W = 128;
  localparam int GRP_W = 124;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic             stall = 1'b0;
  logic [GRP_W-1:0] startGroup = '0;
  logic [GRP_W-1:0] finalGroup = '0;
  logic [KEY_W-1:0] keyOut;
  logic [GRP_W-1:0] groupIdx;
  logic [3:0]       memberIdx;
  logic             keyValid;
  logic             done;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // model state
  bit               mValid = 0;
  bit               mDone = 0;
  logic [GRP_W-1:0] mGroup = '0;
  logic [3:0]       mMember = '0;
  int               issued = 0;

  always #2 clk = ~clk;  // 250 MHz

  keyGroupEnum i_keyGroupEnum (
    .clk(clk), .rstN(rstN), .start(start), .stall(stall),
    .startGroup(startGroup), .finalGroup(finalGroup),
    .keyOut(keyOut), .groupIdx(groupIdx), .memberIdx(memberIdx),
    .keyValid(keyValid), .done(done)
  );

  // R2 expectation: offsets in bytes 0 and 5, group bits fill the rest ascending
  function automatic logic [KEY_W-1:0] expKey(logic [GRP_W-1:0] g, logic [3:0] m);
    logic [KEY_W-1:0] k;
    int gi = 0;
    for (int b = 0; b < KEY_W; b++) begin
      if (b == 0 || b == 1)        k[b] = m[b];
      else if (b == 40 || b == 41) k[b] = m[b - 40 + 2];
      else begin k[b] = g[gi]; gi++; end
    end
    return k;
  endfunction

  function automatic logic [GRP_W-1:0] rndGroup();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(bit ok, string req, logic [KEY_W-1:0] act, logic [KEY_W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compareAll();
    check(keyValid == mValid, "R5 keyValid", KEY_W'(keyValid), KEY_W'(mValid));
    check(done == mDone, "R7 done", KEY_W'(done), KEY_W'(mDone));
    if (mValid) begin
      check(memberIdx == mMember, "R3 memberIdx", KEY_W'(memberIdx), KEY_W'(mMember));
      check(groupIdx == mGroup, "R4 groupIdx", KEY_W'(groupIdx), KEY_W'(mGroup));
      check(keyOut == expKey(mGroup, mMember), "R2 keyOut", keyOut, expKey(mGroup, mMember));
    end
  endtask

  // one clock: drive at negedge, advance model, compare at next negedge
  task automatic tick(bit st, bit sl);
    bit nd = 0;
    start = st;
    stall = sl;
    if (!st && mValid && !sl) issued++;
    if (st) begin
      mValid = 1; mGroup = startGroup; mMember = '0;
    end else if (mValid && !sl) begin
      if (mMember == 4'hF && mGroup == finalGroup) begin
        mValid = 0; nd = 1;
      end else begin
        if (mMember == 4'hF) mGroup = mGroup + 1'b1;
        mMember = mMember + 1'b1;
      end
    end
    mDone = nd;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    compareAll();
  endtask

  // run a sweep to completion; returns keys issued
  task automatic sweep(logic [GRP_W-1:0] sg, logic [GRP_W-1:0] fg, int stallPct, output int n);
    startGroup = sg;
    finalGroup = fg;
    issued = 0;
    tick(1, 0);
    check(keyValid && memberIdx == 0 && groupIdx == sg, "R6 start load",
          KEY_W'(groupIdx), KEY_W'(sg));
    for (int c = 0; c < 2000 && mValid; c++)
      tick(0, ($urandom_range(0, 99) < stallPct));
    tick(0, 0);
    n = issued;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [GRP_W-1:0] g;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(keyValid == 0 && done == 0, "R1 reset", KEY_W'({keyValid, done}), '0);
    rstN = 1'b1;
    @(negedge clk);
    tick(0, 1);  // idle with stall: nothing happens

    // three groups with random stalls
    g = rndGroup();
    sweep(g, g + 2, 30, n);
    check(n == 48, "R7 three-group count", KEY_W'(n), KEY_W'(48));

    // wrap through group 0 (R4, R8)
    sweep('1, 124'd1, 0, n);
    check(n == 48, "R8 wrap count", KEY_W'(n), KEY_W'(48));

    // single group (R8)
    g = rndGroup();
    sweep(g, g, 50, n);
    check(n == 16, "R8 single group", KEY_W'(n), KEY_W'(16));

    // restart in the middle of a sweep (R6)
    g = rndGroup();
    startGroup = g;
    finalGroup = g + 5;
    tick(1, 0);
    for (int c = 0; c < 20; c++) tick(0, ($urandom_range(0, 3) == 0));
    g = rndGroup();
    sweep(g, g, 20, n);
    check(n == 16, "R6 restart count", KEY_W'(n), KEY_W'(16));

    // long stall on the final key, then release (R5, R7)
    g = rndGroup();
    startGroup = g;
    finalGroup = g;
    tick(1, 0);
    for (int c = 0; c < 15; c++) tick(0, 0);
    for (int c = 0; c < 6; c++) tick(0, 1);
    check(keyValid && memberIdx == 4'hF, "R5 hold last", KEY_W'(memberIdx), KEY_W'(15));
    tick(0, 0);
    check(!keyValid && done, "R7 done after last", KEY_W'({keyValid, done}), KEY_W'(1));
    tick(0, 0);
    check(!done, "R7 done one cycle", KEY_W'(done), '0);

    // random sweeps
    for (int r = 0; r < 4; r++) begin
      g = rndGroup();
      sweep(g, g + 124'($urandom_range(0, 3)), 25, n);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule